// File: doc/BRIEF.md
# Split-Width Event Counter Bank

This block holds eight event counters behind a 64-bit register port. Each counter is either one 32-bit count or two separate 16-bit counts. The choice is made per counter by a size bit in a single control register, which also carries a global enable. Software reaches the counters through sixteen logical counter numbers. When a counter is split, one logical number names its upper half and the other names its lower half.

A host write to a counter does not change the running count straight away. The value goes into a per-counter staging latch, and a pending flag is raised. Reads return the staged value while the flag is set. Any write to the control register that has the enable bit set loads every staged value into its counter and clears all pending flags in the same cycle. This holds whether the unit is being switched on or is already running. It lets several counters be preset and then started together.

Top module: `pmc_bank`

## Requirements
- R1: After a synchronous reset, every counter, staging latch, pending flag and the control register are zero, so every read returns zero.
- R2: The control register sits at address 0. Bit 31 of the control value is the enable, and bit p (p = 0..7) is the split bit of counter p. A 32-bit register value travels in wdata[63:32] and rdata[63:32], and rdata[31:0] always reads zero. Logical counter n (0..15) is at address 16+n. Addresses 1 to 15 read as zero, and writes to them have no effect.
- R3: An enabled, unsplit counter p adds ev_lo[p] each cycle across the full 32 bits, carrying from bit 15 into bit 16. ev_hi[p] has no effect on it.
- R4: An enabled, split counter p adds ev_hi[p] to bits 31:16 and ev_lo[p] to bits 15:0. Each half wraps from 0xFFFF to 0 with no carry into the other half.
- R5: Logical n selects physical counter n mod 8. When that counter is split, n < 8 selects the upper half and n >= 8 selects the lower half, read and written as the low 16 bits of the 32-bit value, with the upper 16 bits of the read value zero. When the counter is unsplit, both logical numbers access all 32 bits.
- R6: A counter write loads only the staging latch and sets that counter's pending flag. While the flag is set, reads return the latch value.
- R7: A 16-bit logical write changes only the selected half. The other half keeps the value of the latch if the counter is pending, and otherwise the value of the live count.
- R8: A control write whose enable bit is set loads every pending latch into its counter and clears all pending flags in that cycle. A counter with no pending value is not disturbed by it.
- R9: While the enable bit is clear, no counter changes except through a commit, so the counts are held.
- R10: When an event and a commit reach the same pending counter in one cycle, the counter takes the committed value and the event is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for reads and writes |
| wdata | input | 64 | Write data; the value is in bits 63:32 |
| rdata | output | 64 | Combinational read data for addr; the value is in bits 63:32 |
| ev_lo | input | 8 | Per-counter event pulses for the lower half, or for the full count when unsplit |
| ev_hi | input | 8 | Per-counter event pulses for the upper half when split |

## Verification
The port has a single write strobe and one address, so the checks assume that a counter write and a commit never fall in the same cycle. The stimulus meets this by driving one register operation per cycle. Events are arbitrary per-cycle pulses. The bench drives them alongside control writes, including in the same cycle as a commit, to reach the R10 corner. The no-carry and hold properties assume that the size bits and the enable bit observed in a cycle are the ones that govern that cycle's update. For that reason the bench changes the control register only through its ordinary write path, on the falling clock edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int CTR_N  = 8;
    localparam int CNT_W  = 32;
    localparam int HALF_W = CNT_W / 2;
    localparam int BUS_W  = 64;
    localparam int ADDR_W = 5;
    localparam int SEL_W  = $clog2(CTR_N);
    localparam int LOG_W  = SEL_W + 1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        logic                      enable;
        logic [CNT_W-2-CTR_N:0]    rsvd;
        logic [CTR_N-1:0]          split;
    } ctrl_t;

    // Next count value for one cycle of events.
    function automatic cnt_t next_count(cnt_t c, logic split, logic ev_lo, logic ev_hi);
        if (split)
            return {c[CNT_W-1:HALF_W] + half_t'(ev_hi), c[HALF_W-1:0] + half_t'(ev_lo)};
        return c + cnt_t'(ev_lo);
    endfunction

    // Replace one half of base with v, keeping the other half.
    function automatic cnt_t merge_half(cnt_t base, half_t v, logic upper);
        return upper ? {v, base[HALF_W-1:0]} : {base[CNT_W-1:HALF_W], v};
    endfunction

    // Logical view of a physical value.
    function automatic cnt_t pick_view(cnt_t v, logic split, logic upper);
        if (!split) return v;
        return upper ? cnt_t'(v[CNT_W-1:HALF_W]) : cnt_t'(v[HALF_W-1:0]);
    endfunction
endpackage

// File: rtl/pmc_slice.sv
module pmc_slice
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic split,
    input  logic ev_lo,
    input  logic ev_hi,
    input  logic commit,
    input  logic ld,
    input  cnt_t ld_val,
    output cnt_t view,
    output cnt_t cnt_o,
    output logic pend_o
);
    cnt_t cnt_q, lat_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lat_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (commit && pend_q)
                cnt_q <= lat_q;
            else if (en)
                cnt_q <= next_count(cnt_q, split, ev_lo, ev_hi);

            if (commit)
                pend_q <= 1'b0;
            else if (ld)
                pend_q <= 1'b1;

            if (ld)
                lat_q <= ld_val;
        end
    end

    assign view   = pend_q ? lat_q : cnt_q;
    assign cnt_o  = cnt_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/pmc_regif.sv
module pmc_regif
    import pmc_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  ctrl_t             ctrl_q,
    input  cnt_t              views [CTR_N],
    output logic              ctrl_wr,
    output logic              commit,
    output logic [CTR_N-1:0]  ld,
    output cnt_t              ld_val,
    output logic [BUS_W-1:0]  rdata
);
    logic             is_ctr, upper, sp;
    logic [LOG_W-1:0] lnum;
    logic [SEL_W-1:0] phys;
    cnt_t             wval, base;

    assign is_ctr  = addr[ADDR_W-1];
    assign lnum    = addr[LOG_W-1:0];
    assign phys    = lnum[SEL_W-1:0];
    assign upper   = ~lnum[SEL_W];
    assign wval    = wdata[BUS_W-1 -: CNT_W];
    assign base    = views[phys];
    assign sp      = ctrl_q.split[phys];

    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
    assign commit  = ctrl_wr && wval[CNT_W-1];
    assign ld_val  = sp ? merge_half(base, wval[HALF_W-1:0], upper) : wval;

    for (genvar i = 0; i < CTR_N; i++) begin : g_ld
        assign ld[i] = wr_en && is_ctr && (phys == SEL_W'(i));
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR)
            rdata = {ctrl_q, {(BUS_W-CNT_W){1'b0}}};
        else if (is_ctr)
            rdata = {pick_view(base, sp, upper), {(BUS_W-CNT_W){1'b0}}};
    end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [CTR_N-1:0]  ev_lo,
    input  logic [CTR_N-1:0]  ev_hi
);
    ctrl_t                   ctrl_q;
    logic                    ctrl_wr, commit;
    logic [CTR_N-1:0]        ld, pend_q;
    cnt_t                    ld_val;
    cnt_t                    views [CTR_N];
    cnt_t                    cnt_q [CTR_N];
    logic [CTR_N*CNT_W-1:0]  cnt_flat;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[BUS_W-1 -: CNT_W]);
    end

    pmc_regif u_regif (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .ctrl_q  (ctrl_q),
        .views   (views),
        .ctrl_wr (ctrl_wr),
        .commit  (commit),
        .ld      (ld),
        .ld_val  (ld_val),
        .rdata   (rdata)
    );

    for (genvar i = 0; i < CTR_N; i++) begin : g_ctr
        pmc_slice u_slice (
            .clk    (clk),
            .rst    (rst),
            .en     (ctrl_q.enable),
            .split  (ctrl_q.split[i]),
            .ev_lo  (ev_lo[i]),
            .ev_hi  (ev_hi[i]),
            .commit (commit),
            .ld     (ld[i]),
            .ld_val (ld_val),
            .view   (views[i]),
            .cnt_o  (cnt_q[i]),
            .pend_o (pend_q[i])
        );
        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
    end
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
    import pmc_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [BUS_W-1:0]        rdata,
    input logic                    commit,
    input logic [CTR_N-1:0]        ld,
    input logic [CTR_N-1:0]        pend,
    input logic                    en,
    input logic [CTR_N-1:0]        split,
    input logic [CTR_N*CNT_W-1:0]  cnt_flat,
    input logic [CTR_N-1:0]        ev_hi
);
    assert_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rdata[BUS_W-CNT_W-1:0] == '0);

    assert_commit_clears_R8: assert property (@(posedge clk) disable iff (rst)
        commit |=> (pend == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!en && !commit) |=> $stable(cnt_flat));

    for (genvar i = 0; i < CTR_N; i++) begin : g_chk
        assert_stage_pending_R6: assert property (@(posedge clk) disable iff (rst)
            (ld[i] && !commit) |=> pend[i]);

        assert_no_carry_R4: assert property (@(posedge clk) disable iff (rst)
            (en && split[i] && !ev_hi[i] && !commit)
                |=> $stable(cnt_flat[i*CNT_W+HALF_W +: HALF_W]));
    end
endmodule

bind pmc_bank pmc_bank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rdata    (rdata),
    .commit   (commit),
    .ld       (ld),
    .pend     (pend_q),
    .en       (ctrl_q.enable),
    .split    (ctrl_q.split),
    .cnt_flat (cnt_flat),
    .ev_hi    (ev_hi)
);

// File: tb/tb_pmc_bank.sv
module tb_pmc_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [7:0]  ev_lo = '0;
    logic [7:0]  ev_hi = '0;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_cnt [8];
    logic [31:0] m_lat [8];
    logic        m_pend [8];
    logic [31:0] m_ctrl;

    always #4 clk = ~clk;

    pmc_bank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_lo(ev_lo), .ev_hi(ev_hi)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int n);
        int p = n % 8;
        logic [31:0] v = m_pend[p] ? m_lat[p] : m_cnt[p];
        if (!m_ctrl[p]) return v;
        return (n < 8) ? {16'h0, v[31:16]} : {16'h0, v[15:0]};
    endfunction

    // One clock cycle of stimulus with the matching model update.
    task automatic step(input logic w, input logic [4:0] a, input logic [31:0] d,
                        input logic [7:0] lo, input logic [7:0] hi);
        logic commit;
        logic [31:0] base;
        int p;
        @(negedge clk);
        wr_en = w; addr = a; wdata = {d, 32'h0}; ev_lo = lo; ev_hi = hi;
        commit = w && (a == 5'd0) && d[31];
        if (w && a[4]) begin
            p = int'(a[2:0]);
            base = m_pend[p] ? m_lat[p] : m_cnt[p];
            if (m_ctrl[p])
                m_lat[p] = a[3] ? {base[31:16], d[15:0]} : {d[15:0], base[15:0]};
            else
                m_lat[p] = d;
            m_pend[p] = 1'b1;
        end
        for (int i = 0; i < 8; i++) begin
            if (commit && m_pend[i])
                m_cnt[i] = m_lat[i];
            else if (m_ctrl[31]) begin
                if (m_ctrl[i])
                    m_cnt[i] = {m_cnt[i][31:16] + 16'(hi[i]), m_cnt[i][15:0] + 16'(lo[i])};
                else
                    m_cnt[i] = m_cnt[i] + 32'(lo[i]);
            end
            if (commit) m_pend[i] = 1'b0;
        end
        if (w && a == 5'd0) m_ctrl = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; ev_lo = '0; ev_hi = '0;
    endtask

    task automatic check_all(input string tag);
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            addr = 5'(16 + n);
            #1;
            chk(tag, $sformatf("logical %0d", n), rdata, {exp_rd(n), 32'h0});
        end
        @(negedge clk);
        addr = 5'd0;
        #1;
        chk(tag, "control", rdata, {m_ctrl, 32'h0});
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_cnt[i] = '0; m_lat[i] = '0; m_pend[i] = 1'b0;
        end
        m_ctrl = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        check_all("R1");

        // R2: unmapped addresses read zero and ignore writes
        step(1'b1, 5'd7, 32'hDEAD_BEEF, '0, '0);
        for (int a = 1; a < 16; a++) begin
            @(negedge clk);
            addr = 5'(a);
            #1;
            chk("R2", $sformatf("unmapped addr %0d", a), rdata, 64'h0);
        end
        check_all("R2");

        // R6: staged writes, 32-bit mode, unit disabled
        for (int p = 0; p < 8; p++)
            step(1'b1, 5'(16 + p), 32'h0100_0000 * p + 32'h0000_FFF0, '0, '0);
        check_all("R6");

        // R9: events while disabled have no effect
        for (int k = 0; k < 4; k++) step(1'b0, 5'd0, '0, 8'hFF, 8'hFF);
        check_all("R9");

        // R8: enable commits all staged values
        step(1'b1, 5'd0, 32'h8000_0000, '0, '0);
        check_all("R8");

        // R3: 32-bit counting carries past bit 15, ev_hi ignored
        for (int k = 0; k < 20; k++) step(1'b0, 5'd0, '0, 8'hFF, 8'hFF);
        for (int k = 0; k < 5; k++)  step(1'b0, 5'd0, '0, 8'hAA, 8'h55);
        check_all("R3");

        // R8: commit with nothing pending leaves counters alone; split 4..7
        step(1'b1, 5'd0, 32'h8000_00F0, '0, '0);
        check_all("R5");

        // R7: 16-bit logical writes merge with the live count
        step(1'b1, 5'd20, 32'h0000_ABCD, '0, '0);   // logical 4: upper of phys 4
        step(1'b1, 5'd29, 32'h0000_FFFE, '0, '0);   // logical 13: lower of phys 5
        check_all("R7");

        // R8: rewrite of control while enabled commits
        step(1'b1, 5'd0, 32'h8000_00F0, '0, '0);
        check_all("R8");

        // R4: split halves count separately and wrap without carry
        for (int k = 0; k < 3; k++) step(1'b0, 5'd0, '0, 8'hFF, 8'h0F);
        check_all("R4");
        step(1'b1, 5'd22, 32'h0000_FFFF, '0, '0);
        step(1'b1, 5'd0, 32'h8000_00F0, '0, '0);
        for (int k = 0; k < 2; k++) step(1'b0, 5'd0, '0, 8'h00, 8'hFF);
        check_all("R4");

        // R7: second half write merges with the pending latch
        step(1'b1, 5'd20, 32'h0000_1234, '0, '0);
        step(1'b1, 5'd28, 32'h0000_5678, '0, '0);
        check_all("R7");

        // R10: commit and events in the same cycle
        step(1'b1, 5'd0, 32'h8000_00F0, 8'hFF, 8'hFF);
        check_all("R10");

        // R9: disable holds values
        step(1'b1, 5'd0, 32'h0000_00F0, '0, '0);
        for (int k = 0; k < 5; k++) step(1'b0, 5'd0, '0, 8'hFF, 8'hFF);
        check_all("R9");

        // R5: sweep logical writes over every counter in mixed modes
        for (int n = 0; n < 16; n++)
            step(1'b1, 5'(16 + n), 32'h0000_0101 * (n + 1), '0, '0);
        check_all("R5");
        step(1'b1, 5'd0, 32'h8000_005A, '0, '0);
        for (int k = 0; k < 7; k++) step(1'b0, 5'd0, '0, 8'(k * 37), 8'(k * 91));
        check_all("R5");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule